// File: doc/BRIEF.md
# Lockable Translation Cache with Software Replacement Pointer

This block is a small fully associative translation cache for a device-side memory management unit. It holds `NENT` entries (8 or 32, fixed at elaboration). Each entry pairs a tag word with a data word. The tag word carries the virtual page tag, a two-bit page-size code, a keep flag and a valid bit. The data word carries the physical page address, and its low bits hold free attribute bits.

Software drives the block through one register write port. It sets a lock/pointer register and stages a tag word and a data word. It then issues load, single-entry flush or global flush commands. The pointer field picks the slot that a load fills. The same field picks which entry the two read-back outputs show. Entries below the lock base that carry the keep flag survive a global flush.

A combinational lookup port translates a device address in the same cycle. When several entries match, the lowest-indexed one is used.

Top module: `ltlb_top`

## Requirements
- R1: After a synchronous active-low reset, all entries are invalid and the lock register reads 0. No lookup hits, and `lk_pa` reads 0.
- R2: Writing `wr_sel`=0 loads the lock register. The base field is at bits 14:10 and the pointer field at bits 8:4. `rd_lock` returns these two fields in the same positions, with every other bit 0.
- R3: `wr_sel`=1 stages a tag word and `wr_sel`=2 stages a data word. `wr_sel`=3 with `wr_data[0]`=1 copies the staged words into the entry the pointer selects, with tag bit 2 (valid) forced to 1. The other tag bits are bit 3 (keep), bits 1:0 (size code) and bits 31:12 (tag).
- R4: Each accepted load advances the pointer by one. When the incremented value would equal `NENT`, the pointer takes the base value instead.
- R5: `rd_cam` and `rd_ram` show the tag and data words of the entry the pointer selects. When the pointer is `NENT` or above, both read 0 and a load is ignored.
- R6: `wr_sel`=5 with `wr_data[0]`=1 clears the valid bit of every entry, except entries whose index is below the base and whose keep bit is set. Only the valid bit is cleared.
- R7: `wr_sel`=4 with `wr_data[0]`=1 clears the valid bit of every valid entry whose page contains the address held in the staged tag word.
- R8: Size code 0, 1, 2 and 3 selects a 4 KB, 64 KB, 1 MB or 16 MB page. A lookup hits when a valid entry's tag matches `lk_va` above the page size. On a hit, `lk_pa` is the data word above the page size joined with the in-page offset of `lk_va`.
- R9: When several valid entries match, the lowest-indexed one supplies `lk_pa`.
- R10: When the base is `NENT` or above, a load command changes neither the entries nor the pointer.
- R11: Load and flush commands whose `wr_data[0]` is 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Target: 0 lock, 1 tag stage, 2 data stage, 3 load, 4 flush one, 5 flush all |
| wr_data | input | 32 | Write data |
| rd_lock | output | 32 | Lock register read-back |
| rd_cam | output | 32 | Tag word of the pointed entry |
| rd_ram | output | 32 | Data word of the pointed entry |
| lk_va | input | 32 | Lookup device address |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | 32 | Translated address |

## Verification
The bench goes after the following corner cases:
- **Pointer wrap with a non-zero base.** A design that wrapped to 0 would overwrite locked slots.
- **Global flush.** The bench mixes kept entries below the base with kept entries above it. A design that ignored either condition would keep too much or lose locked translations.
- **Overlapping pages of different sizes.** These expose a wrong priority order or a wrong per-size mask, which shows up as the wrong physical address or the wrong offset bits.
- **Loads while the lock is full or the pointer is out of range, and commands with bit 0 clear.** These must leave every read-back value unchanged. A design that missed this would corrupt entries silently.

// File: rtl/ltlb_pkg.sv
// Shared field positions, command codes and page-size decode for the
// lockable translation cache. Assumes 32-bit addresses and 4 KB minimum pages.
package ltlb_pkg;
    localparam int FLD_W     = 5;
    localparam int BASE_LSB  = 10;
    localparam int VICT_LSB  = 4;
    localparam int VALID_BIT = 2;
    localparam int KEEP_BIT  = 3;

    typedef enum logic [2:0] {
        SEL_LOCK      = 3'd0,
        SEL_TAG       = 3'd1,
        SEL_DATA      = 3'd2,
        SEL_LOAD      = 3'd3,
        SEL_FLUSH_ONE = 3'd4,
        SEL_FLUSH_ALL = 3'd5
    } cmd_sel_e;

    // Address bits above the page offset for a size code.
    function automatic logic [31:0] span_mask(input logic [1:0] code);
        case (code)
            2'd0:    span_mask = 32'hFFFF_F000;
            2'd1:    span_mask = 32'hFFFF_0000;
            2'd2:    span_mask = 32'hFFF0_0000;
            default: span_mask = 32'hFF00_0000;
        endcase
    endfunction
endpackage

// File: rtl/ltlb_lockreg.sv
// Lock register: base and replacement pointer, with the pointer advance
// after each accepted load. Assumes at most one write request per cycle.
module ltlb_lockreg
    import ltlb_pkg::*;
#(
    parameter int NENT = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_we,
    input  logic [31:0]      lock_wd,
    input  logic             load_req,
    output logic [FLD_W-1:0] base_q,
    output logic [FLD_W-1:0] vict_q,
    output logic             load_ok
);
    logic [FLD_W-1:0] vict_inc;

    // Accept a load only while the lock is not full and the pointer is in range.
    assign load_ok  = load_req && (32'(base_q) < NENT) && (32'(vict_q) < NENT);
    // Next pointer value, wrapping back to the base at the entry count.
    assign vict_inc = (32'(vict_q) + 1 == NENT) ? base_q : vict_q + 1'b1;

    // Register update: software write, or pointer advance on a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            vict_q <= '0;
        end else if (lock_we) begin
            base_q <= lock_wd[BASE_LSB +: FLD_W];
            vict_q <= lock_wd[VICT_LSB +: FLD_W];
        end else if (load_ok) begin
            vict_q <= vict_inc;
        end
    end

    p_full_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && 32'(base_q) >= NENT) |=> $stable(vict_q));
    p_wrap_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_ok && 32'(vict_q) == NENT - 1) |=> (vict_q == $past(base_q)));
endmodule

// File: rtl/ltlb_entries.sv
// Entry storage with per-entry tag compare for lookup and single flush.
// Assumes load, flush-one and flush-all never arrive in the same cycle.
module ltlb_entries
    import ltlb_pkg::*;
#(
    parameter int NENT = 32,
    parameter int IW   = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ld_go,
    input  logic [IW-1:0]          ld_idx,
    input  logic [31:0]            ld_cam,
    input  logic [31:0]            ld_ram,
    input  logic                   fl_one,
    input  logic [31:0]            fl_addr,
    input  logic                   fl_all,
    input  logic [FLD_W-1:0]       keep_base,
    input  logic [31:0]            lk_va,
    output logic [NENT-1:0]        hit_vec,
    output logic [NENT-1:0][31:0]  cam_q,
    output logic [NENT-1:0][31:0]  ram_q
);
    logic [NENT-1:0][31:0] cam_r;
    logic [NENT-1:0][31:0] ram_r;

    // Entry update: load into one slot, or clear valid bits on a flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cam_r <= '0;
            ram_r <= '0;
        end else begin
            for (int i = 0; i < NENT; i++) begin
                if (ld_go && 32'(ld_idx) == i) begin
                    cam_r[i]            <= ld_cam;
                    cam_r[i][VALID_BIT] <= 1'b1;
                    ram_r[i]            <= ld_ram;
                end else if (fl_all && !((i < 32'(keep_base)) && cam_r[i][KEEP_BIT])) begin
                    cam_r[i][VALID_BIT] <= 1'b0;
                end else if (fl_one &&
                             (((fl_addr ^ cam_r[i]) & span_mask(cam_r[i][1:0])) == 32'd0)) begin
                    cam_r[i][VALID_BIT] <= 1'b0;
                end
            end
        end
    end

    assign cam_q = cam_r;
    assign ram_q = ram_r;

    for (genvar g = 0; g < NENT; g++) begin : g_cmp
        // Lookup match for one entry under its own page size.
        assign hit_vec[g] = cam_r[g][VALID_BIT] &&
                            (((lk_va ^ cam_r[g]) & span_mask(cam_r[g][1:0])) == 32'd0);

        p_load_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (ld_go && 32'(ld_idx) == g) |=> cam_q[g][VALID_BIT]);
        p_keep_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (fl_all && !ld_go && (g < 32'(keep_base)) && cam_q[g][KEEP_BIT] && cam_q[g][VALID_BIT])
            |=> cam_q[g][VALID_BIT]);
    end
endmodule

// File: rtl/ltlb_pick.sv
// Lowest-index priority select over the per-entry match vector.
// Assumes the match vector is purely combinational from the lookup address.
module ltlb_pick #(
    parameter int NENT = 32,
    parameter int IW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NENT-1:0] hit_vec,
    output logic            any,
    output logic [IW-1:0]   idx,
    output logic [NENT-1:0] grant
);
    // Scan from the top so the lowest matching index is the one kept.
    always_comb begin
        idx = '0;
        for (int i = NENT - 1; i >= 0; i--) begin
            if (hit_vec[i]) idx = IW'(i);
        end
    end

    assign any   = |hit_vec;
    assign grant = hit_vec & (~hit_vec + 1'b1);

    p_lowest_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (grant[idx] && $onehot(grant)));
endmodule

// File: rtl/ltlb_top.sv
// Lockable fully associative translation cache: register decode, staging
// words, read-back mux and lookup output. Assumes NENT is 8 or 32.
module ltlb_top
    import ltlb_pkg::*;
#(
    parameter int NENT = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_lock,
    output logic [31:0] rd_cam,
    output logic [31:0] rd_ram,
    input  logic [31:0] lk_va,
    output logic        lk_hit,
    output logic [31:0] lk_pa
);
    localparam int IW = (NENT > 1) ? $clog2(NENT) : 1;

    logic [31:0]           tag_stage, data_stage;
    logic [FLD_W-1:0]      base_q, vict_q;
    logic                  load_ok, vict_in;
    logic [NENT-1:0]       hit_vec, grant;
    logic [NENT-1:0][31:0] cam_q, ram_q;
    logic [IW-1:0]         win;
    logic                  any;
    logic [31:0]           pmask;
    cmd_sel_e              sel;

    initial assert (NENT == 8 || NENT == 32) else $error("NENT must be 8 or 32");

    assign sel = cmd_sel_e'(wr_sel);

    // Staging words written by software ahead of a load or single flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_stage  <= '0;
            data_stage <= '0;
        end else if (wr_en && sel == SEL_TAG) begin
            tag_stage  <= wr_data;
        end else if (wr_en && sel == SEL_DATA) begin
            data_stage <= wr_data;
        end
    end

    ltlb_lockreg #(.NENT(NENT)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_we  (wr_en && sel == SEL_LOCK),
        .lock_wd  (wr_data),
        .load_req (wr_en && sel == SEL_LOAD && wr_data[0]),
        .base_q   (base_q),
        .vict_q   (vict_q),
        .load_ok  (load_ok)
    );

    ltlb_entries #(.NENT(NENT), .IW(IW)) u_ent (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_go     (load_ok),
        .ld_idx    (vict_q[IW-1:0]),
        .ld_cam    (tag_stage),
        .ld_ram    (data_stage),
        .fl_one    (wr_en && sel == SEL_FLUSH_ONE && wr_data[0]),
        .fl_addr   (tag_stage),
        .fl_all    (wr_en && sel == SEL_FLUSH_ALL && wr_data[0]),
        .keep_base (base_q),
        .lk_va     (lk_va),
        .hit_vec   (hit_vec),
        .cam_q     (cam_q),
        .ram_q     (ram_q)
    );

    ltlb_pick #(.NENT(NENT), .IW(IW)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_vec (hit_vec),
        .any     (any),
        .idx     (win),
        .grant   (grant)
    );

    // Read-back of the lock fields and of the pointed entry.
    assign vict_in = 32'(vict_q) < NENT;
    always_comb begin
        rd_lock = '0;
        rd_lock[BASE_LSB +: FLD_W] = base_q;
        rd_lock[VICT_LSB +: FLD_W] = vict_q;
        rd_cam  = vict_in ? cam_q[vict_q[IW-1:0]] : 32'd0;
        rd_ram  = vict_in ? ram_q[vict_q[IW-1:0]] : 32'd0;
    end

    // Translation: page frame from the winning entry, offset from the address.
    assign pmask  = span_mask(cam_q[win][1:0]);
    assign lk_hit = any;
    assign lk_pa  = any ? ((ram_q[win] & pmask) | (lk_va & ~pmask)) : 32'd0;

    p_offset_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_pa[11:0] == lk_va[11:0]));
    p_no_hit_after_reset_r1: assert property (@(posedge clk)
        !rst_n |=> !lk_hit);
endmodule

// File: tb/ltlb_top_test.sv
module ltlb_top_test;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd0;
    logic [31:0] wr_data = 32'd0;
    logic [31:0] lk_va = 32'd0;
    logic [31:0] rd_lock, rd_cam, rd_ram, lk_pa;
    logic        lk_hit;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit cmp_on = 0;
    string cur_req = "R1";

    // behavioural model state
    logic [31:0] m_cam [N];
    logic [31:0] m_ram [N];
    int m_base = 0, m_vict = 0;
    logic [31:0] m_tag = 0, m_dat = 0;

    ltlb_top #(.NENT(N)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_lock(rd_lock), .rd_cam(rd_cam), .rd_ram(rd_ram),
        .lk_va(lk_va), .lk_hit(lk_hit), .lk_pa(lk_pa)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] pmask(input logic [1:0] code);
        return ~((32'h1000 << (4 * code)) - 1);
    endfunction

    function automatic bit covers(input logic [31:0] cam, input logic [31:0] a);
        return cam[2] && (((cam ^ a) & pmask(cam[1:0])) == 0);
    endfunction

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s got=%h exp=%h", cur_req, what, got, exp);
        end
    endtask

    // compare model and design every clock, away from the edge
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            logic [31:0] e_lock, e_cam, e_ram, e_pa;
            bit e_hit;
            e_lock = 32'((m_base << 10) | (m_vict << 4));
            e_cam = (m_vict < N) ? m_cam[m_vict] : 32'd0;
            e_ram = (m_vict < N) ? m_ram[m_vict] : 32'd0;
            e_hit = 0; e_pa = 0;
            for (int i = 0; i < N; i++) begin
                if (!e_hit && covers(m_cam[i], lk_va)) begin
                    e_hit = 1;
                    e_pa = (m_ram[i] & pmask(m_cam[i][1:0])) | (lk_va & ~pmask(m_cam[i][1:0]));
                end
            end
            chk("rd_lock", rd_lock, e_lock);
            chk("rd_cam", rd_cam, e_cam);
            chk("rd_ram", rd_ram, e_ram);
            chk("lk_hit", {31'd0, lk_hit}, {31'd0, e_hit});
            chk("lk_pa", lk_pa, e_pa);
        end
    end

    task automatic model_apply(input logic [2:0] s, input logic [31:0] d);
        case (s)
            3'd0: begin m_base = int'(d[14:10]); m_vict = int'(d[8:4]); end
            3'd1: m_tag = d;
            3'd2: m_dat = d;
            3'd3: if (d[0] && m_base < N && m_vict < N) begin
                m_cam[m_vict] = m_tag | 32'h4;
                m_ram[m_vict] = m_dat;
                m_vict = (m_vict + 1 == N) ? m_base : m_vict + 1;
            end
            3'd4: if (d[0]) begin
                for (int i = 0; i < N; i++)
                    if (covers(m_cam[i], m_tag)) m_cam[i][2] = 1'b0;
            end
            3'd5: if (d[0]) begin
                for (int i = 0; i < N; i++)
                    if (!(i < m_base && m_cam[i][3])) m_cam[i][2] = 1'b0;
            end
            default: ;
        endcase
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(posedge clk);
        model_apply(s, d);
        #3;
        wr_en = 1'b0;
    endtask

    task automatic look(input logic [31:0] va);
        lk_va = va;
        @(posedge clk);
        #3;
    endtask

    task automatic load(input logic [31:0] tag, input logic [31:0] dat);
        wr(3'd1, tag);
        wr(3'd2, dat);
        wr(3'd3, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_cam[i] = 0; m_ram[i] = 0; end
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;
        cmp_on = 1;
        // R1: reset state, no hit anywhere
        cur_req = "R1";
        look(32'h1000_0000);
        look(32'h0000_0000);
        // R2: lock field positions
        cur_req = "R2";
        wr(3'd0, (32'd3 << 10) | (32'd5 << 4));
        wr(3'd0, 32'd0);
        // R3: loads of each page size, keep bit on slots 0 and 1
        cur_req = "R3";
        load(32'h1000_0008, 32'hAAAA_A0C3);
        load(32'h2003_0009, 32'h5550_0000);
        load(32'h3010_0002, 32'h6660_0000);
        load(32'h1000_0003, 32'h7700_0000);
        // R8: translations across sizes plus a miss
        cur_req = "R8";
        look(32'h2003_1234);
        look(32'h301A_BCDE);
        look(32'h1055_4321);
        look(32'h4000_0000);
        // R9: 4K slot 0 and 16M slot 3 both cover this address
        cur_req = "R9";
        look(32'h1000_0FFF);
        // R4: fill to the end, wrap to base 0, then wrap to a non-zero base
        cur_req = "R4";
        for (int i = 4; i < N; i++)
            load(32'h5000_0000 | (i << 12) | ((i == 4) ? 8 : 0), 32'h8000_0000 | (i << 12));
        wr(3'd0, (32'd2 << 10) | (32'd7 << 4));
        load(32'h6000_0000, 32'h9000_0000);
        look(32'h5000_4010);
        // R5: read-back by pointer, out-of-range pointer reads zero and blocks load
        cur_req = "R5";
        wr(3'd0, (32'd2 << 10) | (32'd1 << 4));
        wr(3'd0, (32'd2 << 10) | (32'd20 << 4));
        load(32'h7000_0000, 32'h1111_0000);
        look(32'h7000_0000);
        // R11: commands with bit 0 clear do nothing
        cur_req = "R11";
        wr(3'd0, (32'd2 << 10) | (32'd3 << 4));
        wr(3'd3, 32'd0);
        wr(3'd5, 32'd0);
        wr(3'd4, 32'd0);
        look(32'h1000_0ABC);
        // R7: single flush by an address inside the 64K page of slot 1
        cur_req = "R7";
        wr(3'd1, 32'h2003_8000);
        wr(3'd4, 32'd1);
        wr(3'd0, (32'd2 << 10) | (32'd1 << 4));
        look(32'h2003_1234);
        // R6: global flush keeps slot 0 (kept, below base), drops slot 4 (kept, above)
        cur_req = "R6";
        wr(3'd0, (32'd2 << 10) | (32'd0 << 4));
        wr(3'd5, 32'd1);
        look(32'h1000_0ABC);
        look(32'h5000_4000);
        wr(3'd0, (32'd2 << 10) | (32'd4 << 4));
        // R10: base equal to entry count blocks loads and pointer motion
        cur_req = "R10";
        wr(3'd0, (32'd8 << 10) | (32'd3 << 4));
        load(32'h9000_0000, 32'h2222_0000);
        look(32'h9000_0000);
        done = 1;
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule